// File: doc/BRIEF.md
# Ordered Store Buffer with Read Forwarding

This block is a four-entry queue of pending stores. It sits between the issue port of one processor and a simple memory port. The processor presents one access at a time: a load, a store, an instruction fetch, or one of three barriers (full barrier, write barrier, fetch-sync barrier). It holds the access until it sees a one-cycle `done` pulse. A store is parked in the queue and completes at once. It reaches memory only when something forces it out: the queue is full, a load partially overlaps it, or a barrier arrives. Parked stores always leave oldest first.

A load that lies entirely inside one or more parked stores is answered from the youngest of them, with no memory traffic. A load that touches no parked store goes to memory while the stores stay parked. An instruction fetch always goes straight to memory and may return data that a parked store has already overwritten. A fetch-sync barrier, which empties the queue, makes every older store visible to later fetches. Each access carries a memory-like/non-memory-like tag, which is passed to the memory port.

Top module: `store_order_buf`

## Requirements
- R1: After reset the queue is empty, `done` is low and `mem_req` is low.
- R2: A store (`in_kind` = 1) with fewer than four entries queued completes with `done` and issues no memory request.
- R3: A store that arrives while four entries are queued first writes the single oldest entry to memory, then is queued.
- R4: A load (`in_kind` = 0) whose bytes all lie inside some queued store returns that data from the youngest such store, with no memory request. Data is byte-aligned to the low end of `rsp_data`. The size codes 0/1/2/3 mean 1/2/4/8 bytes.
- R5: A load that overlaps a queued store without being contained in it causes oldest-first writes until no partial overlap is left. It then completes with the program-order value.
- R6: A load that overlaps no queued store makes exactly one memory read and leaves the queue unchanged.
- R7: An instruction fetch (`in_kind` = 2) makes exactly one memory read on the next cycle and ignores queued stores, even overlapping ones.
- R8: A full barrier (3), write barrier (4) or fetch-sync barrier (5) writes every queued entry to memory oldest first. Its `done` rises on the edge that takes the last write acknowledge, or on the next edge when the queue is empty. The queue is then empty.
- R9: Overlapping stores reach memory in issue order, so the youngest bytes remain in memory.
- R10: Once raised, `mem_req` and its address and direction hold steady until `mem_ack`.
- R11: `done` is high for exactly one cycle per access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Access presented; held until `done` |
| in_kind | input | 3 | 0 load, 1 store, 2 fetch, 3 full barrier, 4 write barrier, 5 fetch-sync barrier |
| in_addr | input | AW | Byte address of the access |
| in_size | input | 2 | Size code: 1, 2, 4 or 8 bytes |
| in_wdata | input | 64 | Store data, low byte at `in_addr` |
| in_region | input | 1 | 1 memory-like, 0 non-memory-like |
| done | output | 1 | One-cycle completion pulse |
| rsp_data | output | 64 | Load/fetch result, valid with `done` |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | AW | Memory byte address |
| mem_size | output | 2 | Memory size code |
| mem_wdata | output | 64 | Memory write data |
| mem_region | output | 1 | Region tag of the memory access |
| mem_ack | input | 1 | One-cycle acknowledge |
| mem_rdata | input | 64 | Read data, valid with `mem_ack` |

## Verification
Several properties are checked on every cycle:
- the entry count stays within capacity and matches the valid bits;
- memory requests hold steady until acknowledged;
- `done` is a single pulse;
- a completing barrier leaves the queue empty;
- a fetch reaches memory on the next cycle.

Other behaviour can only be shown by the bench's scenarios against a program-order model:
- which bytes a forwarded load returns;
- the exact number of memory writes and reads each access causes;
- the stale data a fetch sees before a fetch-sync barrier;
- the final memory image after overlapping stores.

// File: rtl/sb_pkg.sv
package sb_pkg;
    localparam int SB_DW = 64;

    typedef enum logic [2:0] {
        K_LOAD  = 3'd0,
        K_STORE = 3'd1,
        K_FETCH = 3'd2,
        K_FULLB = 3'd3,
        K_WRB   = 3'd4,
        K_SYNCB = 3'd5
    } acc_kind_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_MEMW,
        S_MEMR,
        S_RESP
    } sb_state_e;

    function automatic logic [SB_DW-1:0] size_mask(input logic [1:0] code);
        case (code)
            2'd0:    return 64'h0000_0000_0000_00ff;
            2'd1:    return 64'h0000_0000_0000_ffff;
            2'd2:    return 64'h0000_0000_ffff_ffff;
            default: return 64'hffff_ffff_ffff_ffff;
        endcase
    endfunction

    function automatic logic is_barrier(input acc_kind_e k);
        return (k == K_FULLB) || (k == K_WRB) || (k == K_SYNCB);
    endfunction
endpackage

// File: rtl/sb_overlap.sv
module sb_overlap #(
    parameter int AW = 8
) (
    input  logic [AW-1:0] st_addr,
    input  logic [1:0]    st_size,
    input  logic [AW-1:0] rq_addr,
    input  logic [1:0]    rq_size,
    output logic          overlap,
    output logic          contains
);
    logic [AW:0] st_end, rq_end;

    always_comb begin
        st_end   = {1'b0, st_addr} + ((AW+1)'(1) << st_size);
        rq_end   = {1'b0, rq_addr} + ((AW+1)'(1) << rq_size);
        overlap  = ({1'b0, st_addr} < rq_end) && ({1'b0, rq_addr} < st_end);
        contains = (st_addr <= rq_addr) && (rq_end <= st_end);
    end
endmodule

// File: rtl/sb_extract.sv
module sb_extract #(
    parameter int AW = 8
) (
    input  logic [AW-1:0]            st_addr,
    input  logic [sb_pkg::SB_DW-1:0] st_data,
    input  logic [AW-1:0]            rq_addr,
    input  logic [1:0]               rq_size,
    output logic [sb_pkg::SB_DW-1:0] fwd_data
);
    logic [AW-1:0] delta;

    always_comb begin
        delta    = rq_addr - st_addr;
        fwd_data = (st_data >> {delta[2:0], 3'b000}) & sb_pkg::size_mask(rq_size);
    end
endmodule

// File: rtl/store_order_buf.sv
module store_order_buf #(
    parameter int AW    = 8,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [2:0]    in_kind,
    input  logic [AW-1:0] in_addr,
    input  logic [1:0]    in_size,
    input  logic [63:0]   in_wdata,
    input  logic          in_region,
    output logic          done,
    output logic [63:0]   rsp_data,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [1:0]    mem_size,
    output logic [63:0]   mem_wdata,
    output logic          mem_region,
    input  logic          mem_ack,
    input  logic [63:0]   mem_rdata
);
    import sb_pkg::*;

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic             vld;
        logic [AW-1:0]    addr;
        logic [1:0]       size;
        logic [SB_DW-1:0] data;
        logic             region;
    } ent_t;

    typedef struct packed {
        sb_state_e             st;
        ent_t [DEPTH-1:0]      ent;
        logic [PW-1:0]         head;
        logic [CW-1:0]         cnt;
        logic                  done;
        logic [SB_DW-1:0]      rsp;
    } sb_regs_t;

    sb_regs_t r_q, r_d;
    acc_kind_e kind;
    assign kind = acc_kind_e'(in_kind);

    logic [DEPTH-1:0]   ov_s, ct_s, vld_vec;
    logic [SB_DW-1:0]   fwd_s [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        sb_overlap #(.AW(AW)) i_ov (
            .st_addr (r_q.ent[g].addr),
            .st_size (r_q.ent[g].size),
            .rq_addr (in_addr),
            .rq_size (in_size),
            .overlap (ov_s[g]),
            .contains(ct_s[g])
        );
        sb_extract #(.AW(AW)) i_ex (
            .st_addr (r_q.ent[g].addr),
            .st_data (r_q.ent[g].data),
            .rq_addr (in_addr),
            .rq_size (in_size),
            .fwd_data(fwd_s[g])
        );
        assign vld_vec[g] = r_q.ent[g].vld;
    end

    logic             partial, hit;
    logic [SB_DW-1:0] hit_data;
    logic [PW-1:0]    sidx, tail;

    // youngest containing entry wins: scan from oldest to youngest
    always_comb begin
        partial  = |(vld_vec & ov_s & ~ct_s);
        hit      = 1'b0;
        hit_data = '0;
        sidx     = '0;
        for (int a = 0; a < DEPTH; a++) begin
            sidx = PW'((int'(r_q.head) + a) % DEPTH);
            if (a < int'(r_q.cnt) && ct_s[sidx]) begin
                hit      = 1'b1;
                hit_data = fwd_s[sidx];
            end
        end
        tail = PW'((int'(r_q.head) + int'(r_q.cnt)) % DEPTH);
    end

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.st)
            S_IDLE: if (in_valid) begin
                case (kind)
                    K_STORE: begin
                        if (r_q.cnt == CW'(DEPTH)) begin
                            r_d.st = S_MEMW;
                        end else begin
                            r_d.ent[tail] = '{vld: 1'b1, addr: in_addr, size: in_size,
                                              data: in_wdata & size_mask(in_size),
                                              region: in_region};
                            r_d.cnt  = r_q.cnt + CW'(1);
                            r_d.st   = S_RESP;
                            r_d.done = 1'b1;
                        end
                    end
                    K_LOAD: begin
                        if (partial) begin
                            r_d.st = S_MEMW;
                        end else if (hit) begin
                            r_d.rsp  = hit_data;
                            r_d.st   = S_RESP;
                            r_d.done = 1'b1;
                        end else begin
                            r_d.st = S_MEMR;
                        end
                    end
                    K_FETCH: r_d.st = S_MEMR;
                    default: begin
                        if (r_q.cnt != '0) begin
                            r_d.st = S_MEMW;
                        end else begin
                            r_d.st   = S_RESP;
                            r_d.done = 1'b1;
                        end
                    end
                endcase
            end
            S_MEMW: if (mem_ack) begin
                r_d.ent[r_q.head].vld = 1'b0;
                r_d.head = (r_q.head == PW'(DEPTH - 1)) ? '0 : r_q.head + PW'(1);
                r_d.cnt  = r_q.cnt - CW'(1);
                if (is_barrier(kind) && r_q.cnt == CW'(1)) begin
                    r_d.st   = S_RESP;
                    r_d.done = 1'b1;
                end else begin
                    r_d.st = S_IDLE;
                end
            end
            S_MEMR: if (mem_ack) begin
                r_d.rsp  = mem_rdata & size_mask(in_size);
                r_d.st   = S_RESP;
                r_d.done = 1'b1;
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= S_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        mem_req    = (r_q.st == S_MEMW) || (r_q.st == S_MEMR);
        mem_we     = (r_q.st == S_MEMW);
        mem_addr   = mem_we ? r_q.ent[r_q.head].addr   : in_addr;
        mem_size   = mem_we ? r_q.ent[r_q.head].size   : in_size;
        mem_wdata  = mem_we ? r_q.ent[r_q.head].data   : '0;
        mem_region = mem_we ? r_q.ent[r_q.head].region : in_region;
    end

    assign done     = r_q.done;
    assign rsp_data = r_q.rsp;

    // R3
    cap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.cnt <= CW'(DEPTH)) && ($countones(vld_vec) == int'(r_q.cnt)));

    // R10
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    barrier_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && is_barrier(kind)) |-> (r_q.cnt == '0));

    // R7
    fetch_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_IDLE && in_valid && kind == K_FETCH) |=> (mem_req && !mem_we));
endmodule

// File: tb/test_store_order_buf.sv
`timescale 1ns/1ps
module test_store_order_buf;
    localparam int KL = 0, KS = 1, KF = 2, KMB = 3, KWB = 4, KIB = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  in_kind = '0;
    logic [7:0]  in_addr = '0;
    logic [1:0]  in_size = '0;
    logic [63:0] in_wdata = '0;
    logic        in_region = 1'b0;
    logic        done;
    logic [63:0] rsp_data;
    logic        mem_req, mem_we, mem_region;
    logic [7:0]  mem_addr;
    logic [1:0]  mem_size;
    logic [63:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [63:0] mem_rdata = '0;

    always #2.5 clk = ~clk;

    store_order_buf i_store_order_buf (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_kind(in_kind),
        .in_addr(in_addr), .in_size(in_size), .in_wdata(in_wdata), .in_region(in_region),
        .done(done), .rsp_data(rsp_data), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata),
        .mem_region(mem_region), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    int checks = 0, errors = 0, cyc = 0, ack_cyc = 0, wr_cnt = 0, rd_cnt = 0, wait_n = 0;
    bit finished = 0;
    logic [7:0]  mem_arr [256];
    logic [7:0]  ref_mem [256];
    int          q_addr [4];
    int          q_len  [4];
    logic [63:0] q_data [4];
    int          q_n = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // memory model with 0..2 cycles of extra latency
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 1'b0;
            wait_n  = int'($urandom % 3);
        end else if (mem_req) begin
            if (wait_n > 0) wait_n--;
            else begin
                mem_ack = 1'b1;
                ack_cyc = cyc;
                if (mem_we) begin
                    for (int k = 0; k < (1 << mem_size); k++)
                        mem_arr[(int'(mem_addr) + k) % 256] = mem_wdata[8*k +: 8];
                    wr_cnt++;
                end else begin
                    mem_rdata = '0;
                    for (int k = 0; k < (1 << mem_size); k++)
                        mem_rdata[8*k +: 8] = mem_arr[(int'(mem_addr) + k) % 256];
                    rd_cnt++;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic void pop_oldest();
        for (int k = 0; k < q_len[0]; k++) ref_mem[q_addr[0] + k] = q_data[0][8*k +: 8];
        for (int e = 0; e < 3; e++) begin
            q_addr[e] = q_addr[e+1]; q_len[e] = q_len[e+1]; q_data[e] = q_data[e+1];
        end
        q_n--;
    endfunction

    function automatic logic [63:0] arch_read(input int a, input int n);
        logic [63:0] v = '0;
        for (int k = 0; k < n; k++) begin
            logic [7:0] b = ref_mem[a + k];
            for (int e = 0; e < q_n; e++)
                if (a + k >= q_addr[e] && a + k < q_addr[e] + q_len[e])
                    b = q_data[e][8*(a + k - q_addr[e]) +: 8];
            v[8*k +: 8] = b;
        end
        return v;
    endfunction

    function automatic logic [63:0] mem_read(input int a, input int n);
        logic [63:0] v = '0;
        for (int k = 0; k < n; k++) v[8*k +: 8] = ref_mem[a + k];
        return v;
    endfunction

    task automatic issue(input int kind, input int addr, input int sc, input logic [63:0] wd,
                         input logic rg, output logic [63:0] rd);
        @(negedge clk);
        in_valid = 1'b1; in_kind = kind[2:0]; in_addr = addr[7:0];
        in_size = sc[1:0]; in_wdata = wd; in_region = rg;
        do @(negedge clk); while (!done);
        rd = rsp_data;
        in_valid = 1'b0;
    endtask

    task automatic run_op(input int kind, input int addr, input int sc, input logic [63:0] wd_in);
        int n = 1 << sc;
        int w0 = wr_cnt, r0 = rd_cnt, ew = 0, er = 0;
        logic [63:0] wd = (n == 8) ? wd_in : (wd_in & ((64'h1 << (8*n)) - 1));
        logic [63:0] ed = '0, got;
        case (kind)
            KS: begin
                if (q_n == 4) begin pop_oldest(); ew = 1; end
                q_addr[q_n] = addr; q_len[q_n] = n; q_data[q_n] = wd; q_n++;
            end
            KL: begin
                bit again = 1;
                bit cont = 0;
                while (again) begin
                    again = 0;
                    for (int e = 0; e < q_n; e++)
                        if (addr < q_addr[e] + q_len[e] && q_addr[e] < addr + n &&
                            !(q_addr[e] <= addr && addr + n <= q_addr[e] + q_len[e])) again = 1;
                    if (again) begin pop_oldest(); ew++; end
                end
                for (int e = 0; e < q_n; e++)
                    if (q_addr[e] <= addr && addr + n <= q_addr[e] + q_len[e]) cont = 1;
                er = cont ? 0 : 1;
                ed = arch_read(addr, n);
            end
            KF: begin er = 1; ed = mem_read(addr, n); end
            default: while (q_n > 0) begin pop_oldest(); ew++; end
        endcase
        issue(kind, addr, sc, wd, ($urandom % 2) == 1, got);
        case (kind)
            KS: begin
                chk(wr_cnt - w0 == ew, ew ? "R3 drain count" : "R2 no mem write", 64'(wr_cnt - w0), 64'(ew));
                chk(rd_cnt == r0, "R2 no mem read", 64'(rd_cnt - r0), 0);
            end
            KL: begin
                chk(got == ed, er ? "R6 load data" : (ew ? "R5 load data" : "R4 forward data"), got, ed);
                chk(rd_cnt - r0 == er, er ? "R6 one mem read" : "R4 no mem read", 64'(rd_cnt - r0), 64'(er));
                chk(wr_cnt - w0 == ew, ew ? "R5 drain count" : "R6 queue kept", 64'(wr_cnt - w0), 64'(ew));
            end
            KF: begin
                chk(got == ed, "R7 fetch data", got, ed);
                chk(rd_cnt - r0 == 1 && wr_cnt == w0, "R7 fetch traffic", 64'(rd_cnt - r0), 1);
            end
            default: begin
                chk(wr_cnt - w0 == ew, "R8 barrier drains all", 64'(wr_cnt - w0), 64'(ew));
                if (ew > 0) chk(cyc == ack_cyc + 1, "R8 done timing", 64'(cyc - ack_cyc), 1);
            end
        endcase
        @(negedge clk);
        chk(!done, "R11 single pulse", 64'(done), 0);
    endtask

    task automatic mem_image_check(input string tag);
        int bad = 0;
        for (int i = 0; i < 256; i++) if (mem_arr[i] !== ref_mem[i]) bad++;
        chk(bad == 0, tag, 64'(bad), 0);
    endtask

    initial begin
        logic [63:0] dummy;
        void'($urandom(32'd1234));
        for (int i = 0; i < 256; i++) begin
            mem_arr[i] = 8'(i * 7 + 3);
            ref_mem[i] = 8'(i * 7 + 3);
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !mem_req, "R1 reset outputs", {62'd0, done, mem_req}, 0);
        run_op(KL, 40, 2, 0);                       // R1 empty queue: goes to memory
        // R2 / R3: fill four, fifth drains the oldest
        run_op(KS, 16, 3, 64'h1111_2222_3333_4444);
        run_op(KS, 32, 2, 64'h5555_6666);
        run_op(KS, 48, 1, 64'h7777);
        run_op(KS, 56, 0, 64'h88);
        run_op(KS, 64, 3, 64'h99aa_bbcc_ddee_ff00);
        chk(mem_arr[16] == 8'h44 && mem_arr[23] == 8'h11, "R3 oldest written", {mem_arr[23], mem_arr[16]}, 16'h1144);
        // R4 forwarding from inside an 8-byte store
        run_op(KL, 66, 1, 0);
        // R5 partial overlap
        run_op(KL, 30, 2, 0);
        // R7 fetch sees stale memory, then a fetch-sync barrier publishes
        run_op(KS, 120, 2, 64'hdead_beef);
        run_op(KF, 120, 2, 0);
        run_op(KIB, 0, 0, 0);
        run_op(KF, 120, 2, 0);
        chk(rsp_data[31:0] == 32'hdead_beef, "R7 fetch after sync", rsp_data, 64'hdead_beef);
        // R9 overlapping stores in order
        run_op(KS, 80, 3, 64'h0102_0304_0506_0708);
        run_op(KS, 80, 0, 64'haa);
        run_op(KS, 80, 1, 64'hccbb);
        run_op(KMB, 0, 0, 0);
        chk({mem_arr[81], mem_arr[80], mem_arr[82]} == 24'hccbb06, "R9 youngest bytes",
            {mem_arr[81], mem_arr[80], mem_arr[82]}, 24'hccbb06);
        run_op(KWB, 0, 0, 0);                       // R8 empty queue barrier
        // random mix
        for (int t = 0; t < 400; t++) begin
            int r = int'($urandom % 20);
            int k = (r < 7) ? KS : (r < 14) ? KL : (r < 16) ? KF : (r == 16) ? KMB : (r == 17) ? KWB : (r == 18) ? KIB : KL;
            run_op(k, 128 + int'($urandom % 24), int'($urandom % 4), {$urandom, $urandom});
        end
        run_op(KMB, 0, 0, 0);
        mem_image_check("R9 final memory image");
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule